// File: doc/BRIEF.md
# Memory Protection Region Checker

This block decides, for every bus access, whether a set of programmable address regions permits it. Another block writes region descriptors into the checker one region at a time. Each descriptor holds a start address, an end address, a valid flag, a 32-bit rights word covering eight bus masters, and a process identifier with a don't-care mask. For each access the requester supplies the address, the master index, read, write and execute request flags, a supervisor/user mode bit and the current process identifier. A global enable turns checking on or off.

The regions are matched in parallel in one combinational pass. The verdict goes into a register and appears one clock after the access is presented. The verdict gives an allow bit, a hit bit and a two-bit hit class. The class says whether the access missed every region, hit exactly one region, or hit more than one. A downstream error-capture block can use the class to describe a denied access. The checker has no bus protocol of its own: the surrounding fabric presents one access per cycle with a valid strobe.

Masters come in two kinds. Masters 0 to 3 have separate user and supervisor rights, including execute, and can have their rights qualified by a process identifier. Masters 4 to 7 have only read and write enables.

Top module: `mpu_region_checker`

## Requirements
- R1: A region's start address is taken with bits 4:0 forced to zero, so an access to the 32-byte granule that contains the programmed start is inside the region, and the byte just below that granule is outside it.
- R2: A region's end address is taken with bits 4:0 forced to one, so the last byte of the granule that contains the programmed end is inside the region, and the next byte is outside it.
- R3: A region whose valid flag is clear never counts as hit, whatever its bounds and rights.
- R4: With the global enable clear, every access gives allow=1, hit=0 and class 0.
- R5: Masters 0 to 3 own the 6-bit field at rights bits [6n+5:6n]. Bits 2:0 of that field are the user code: bit 2 grants read, bit 1 grants write, bit 0 grants execute. The user code applies when the access is in user mode.
- R6: Bits 4:3 of a master 0 to 3 field are the supervisor code, which applies in supervisor mode: 0 grants read, write and execute; 1 grants read and execute; 2 grants read and write; 3 grants what the user code grants.
- R7: Masters 4 to 7 own the 2-bit field at rights bits [24+2(n-4)+1 : 24+2(n-4)]. Bit 0 of the field grants read and bit 1 grants write. These masters never get execute, and the mode bit does not change their rights.
- R8: When bit 5 (process-ID enable) of a master 0 to 3 field is set, the region counts as hit only if the access's process ID equals the region's process ID on every bit that is clear in the region's mask. When bit 5 is clear, the process ID plays no part.
- R9: With checking enabled, an access is allowed when at least one hit region grants every operation it requests. An access that hits no region is denied.
- R10: The hit class is 0 when no region is hit, 1 when exactly one region is hit, and 2 when two or more regions are hit. hit is 1 exactly when the class is not 0. The value 3 never appears.
- R11: A result appears with res_valid one clock after the access is presented with acc_valid. res_valid is low in cycles that follow no access, and the result outputs then hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write one region descriptor |
| cfg_idx | input | 3 | Region index to write |
| cfg_start | input | 32 | Region start address (bits 4:0 ignored) |
| cfg_end | input | 32 | Region end address (bits 4:0 ignored) |
| cfg_valid | input | 1 | Region valid flag |
| cfg_rights | input | 32 | Per-master rights word |
| cfg_pid | input | 8 | Region process identifier |
| cfg_pid_mask | input | 8 | Process ID bits excluded from the comparison |
| chk_enable | input | 1 | Global checking enable |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | Access byte address |
| acc_master | input | 3 | Requesting master index |
| acc_rd | input | 1 | Read requested |
| acc_wr | input | 1 | Write requested |
| acc_ex | input | 1 | Execute requested |
| acc_super | input | 1 | 1 = supervisor mode, 0 = user mode |
| acc_pid | input | 8 | Process identifier of the access |
| res_valid | output | 1 | Result valid |
| res_hit | output | 1 | At least one region was hit |
| res_allow | output | 1 | Access allowed |
| res_class | output | 2 | Hit class: 0 none, 1 single, 2 multiple |

## Verification
The assertions check the following on every cycle: the one-cycle result timing and the holding of the outputs while idle, the open verdict when checking is disabled, denial of any access that misses every region, denial of execute for masters 4 to 7, and the absence of class value 3. Only the bench's scenarios can show the rest. These are the granule rounding at both region edges, the decode of each user and supervisor code, the masked process-ID comparison, the exclusion of an invalid region, and how rights combine across overlapping regions. Each of these depends on the descriptor contents as well as on the port behaviour.

// File: rtl/mpu_chk_pkg.sv
package mpu_chk_pkg;

  // Granted operations, ordered read, write, execute
  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
  } perm_t;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_ONE   = 2'd1,
    CLS_MULTI = 2'd2
  } hit_class_e;

  localparam int RXW_FIELD_W = 6;
  localparam int RW_FIELD_W  = 2;

  function automatic perm_t user_perm(input logic [2:0] code);
    perm_t p;
    p.rd = code[2];
    p.wr = code[1];
    p.ex = code[0];
    return p;
  endfunction

  function automatic perm_t super_perm(input logic [1:0] scode, input logic [2:0] ucode);
    perm_t p;
    unique case (scode)
      2'd0:    p = '{rd: 1'b1, wr: 1'b1, ex: 1'b1};
      2'd1:    p = '{rd: 1'b1, wr: 1'b0, ex: 1'b1};
      2'd2:    p = '{rd: 1'b1, wr: 1'b1, ex: 1'b0};
      default: p = user_perm(ucode);
    endcase
    return p;
  endfunction

endpackage

// File: rtl/mpu_desc_store.sv
module mpu_desc_store #(
  parameter int NREG     = 8,
  parameter int ADDR_W   = 32,
  parameter int PID_W    = 8,
  parameter int RIGHTS_W = 32,
  localparam int IDX_W   = $clog2(NREG)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [IDX_W-1:0]    idx,
  input  logic [ADDR_W-1:0]   start_in,
  input  logic [ADDR_W-1:0]   end_in,
  input  logic                valid_in,
  input  logic [RIGHTS_W-1:0] rights_in,
  input  logic [PID_W-1:0]    pid_in,
  input  logic [PID_W-1:0]    mask_in,
  output logic [ADDR_W-1:0]   r_start  [NREG],
  output logic [ADDR_W-1:0]   r_end    [NREG],
  output logic                r_valid  [NREG],
  output logic [RIGHTS_W-1:0] r_rights [NREG],
  output logic [PID_W-1:0]    r_pid    [NREG],
  output logic [PID_W-1:0]    r_mask   [NREG]
);

  // All regions are read in parallel every cycle, so the table lives in flops.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) begin
        r_start[i]  <= '0;
        r_end[i]    <= '0;
        r_valid[i]  <= 1'b0;
        r_rights[i] <= '0;
        r_pid[i]    <= '0;
        r_mask[i]   <= '0;
      end
    end else if (we) begin
      for (int i = 0; i < NREG; i++) begin
        if (idx == IDX_W'(i)) begin
          r_start[i]  <= start_in;
          r_end[i]    <= end_in;
          r_valid[i]  <= valid_in;
          r_rights[i] <= rights_in;
          r_pid[i]    <= pid_in;
          r_mask[i]   <= mask_in;
        end
      end
    end
  end

endmodule

// File: rtl/mpu_region_eval.sv
module mpu_region_eval
  import mpu_chk_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PID_W     = 8,
  parameter int GRAN_BITS = 5,
  parameter int NRXW      = 4,
  parameter int NRW       = 4,
  localparam int RIGHTS_W = NRXW * RXW_FIELD_W + NRW * RW_FIELD_W,
  localparam int MST_W    = $clog2(NRXW + NRW),
  localparam int RW_BASE  = NRXW * RXW_FIELD_W
) (
  input  logic [ADDR_W-1:0]   reg_start,
  input  logic [ADDR_W-1:0]   reg_end,
  input  logic                reg_valid,
  input  logic [RIGHTS_W-1:0] reg_rights,
  input  logic [PID_W-1:0]    reg_pid,
  input  logic [PID_W-1:0]    reg_mask,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [MST_W-1:0]    master,
  input  logic                want_rd,
  input  logic                want_wr,
  input  logic                want_ex,
  input  logic                is_super,
  input  logic [PID_W-1:0]    pid,
  output logic                hit,
  output logic                grant
);

  localparam logic [ADDR_W-1:0] GRAN_MASK = ADDR_W'((64'd1 << GRAN_BITS) - 64'd1);

  logic [ADDR_W-1:0]      lo_bound, hi_bound;
  logic                   in_range;
  logic [RXW_FIELD_W-1:0] rxw_fld;
  logic [RW_FIELD_W-1:0]  rw_fld;
  logic                   is_rxw;
  logic                   pid_ok;
  perm_t                  perm;

  assign lo_bound = reg_start & ~GRAN_MASK;
  assign hi_bound = reg_end | GRAN_MASK;
  assign in_range = (addr >= lo_bound) && (addr <= hi_bound);
  assign is_rxw   = (master < MST_W'(NRXW));

  always_comb begin
    rxw_fld = '0;
    rw_fld  = '0;
    for (int m = 0; m < NRXW; m++) begin
      if (master == MST_W'(m)) rxw_fld = reg_rights[m*RXW_FIELD_W +: RXW_FIELD_W];
    end
    for (int m = 0; m < NRW; m++) begin
      if (master == MST_W'(NRXW + m)) rw_fld = reg_rights[RW_BASE + m*RW_FIELD_W +: RW_FIELD_W];
    end
  end

  always_comb begin
    if (is_rxw) begin
      perm   = is_super ? super_perm(rxw_fld[4:3], rxw_fld[2:0]) : user_perm(rxw_fld[2:0]);
      pid_ok = !rxw_fld[5] || (((pid ^ reg_pid) & ~reg_mask) == '0);
    end else begin
      perm   = '{rd: rw_fld[0], wr: rw_fld[1], ex: 1'b0};
      pid_ok = 1'b1;
    end
  end

  assign hit   = reg_valid && in_range && pid_ok;
  assign grant = hit && (!want_rd || perm.rd) && (!want_wr || perm.wr) && (!want_ex || perm.ex);

endmodule

// File: rtl/mpu_verdict.sv
module mpu_verdict
  import mpu_chk_pkg::*;
#(
  parameter int NREG   = 8,
  localparam int CNT_W = $clog2(NREG + 1)
) (
  input  logic [NREG-1:0] hit_vec,
  input  logic [NREG-1:0] grant_vec,
  input  logic            enable,
  output logic            any_hit,
  output logic            allow,
  output hit_class_e      cls
);

  logic [CNT_W-1:0] hit_cnt;

  always_comb begin
    hit_cnt = '0;
    for (int i = 0; i < NREG; i++) hit_cnt = hit_cnt + CNT_W'(hit_vec[i]);
  end

  always_comb begin
    if (!enable) begin
      cls     = CLS_NONE;
      any_hit = 1'b0;
      allow   = 1'b1;
    end else begin
      if (hit_cnt == '0)                cls = CLS_NONE;
      else if (hit_cnt == CNT_W'(1))    cls = CLS_ONE;
      else                              cls = CLS_MULTI;
      any_hit = |hit_vec;
      allow   = |grant_vec;
    end
  end

endmodule

// File: rtl/mpu_region_checker.sv
module mpu_region_checker
  import mpu_chk_pkg::*;
#(
  parameter int NREG      = 8,
  parameter int ADDR_W    = 32,
  parameter int PID_W     = 8,
  parameter int GRAN_BITS = 5,
  parameter int NRXW      = 4,
  parameter int NRW       = 4,
  localparam int RIGHTS_W = NRXW * RXW_FIELD_W + NRW * RW_FIELD_W,
  localparam int MST_W    = $clog2(NRXW + NRW),
  localparam int IDX_W    = $clog2(NREG)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic [ADDR_W-1:0]   cfg_start,
  input  logic [ADDR_W-1:0]   cfg_end,
  input  logic                cfg_valid,
  input  logic [RIGHTS_W-1:0] cfg_rights,
  input  logic [PID_W-1:0]    cfg_pid,
  input  logic [PID_W-1:0]    cfg_pid_mask,
  input  logic                chk_enable,
  input  logic                acc_valid,
  input  logic [ADDR_W-1:0]   acc_addr,
  input  logic [MST_W-1:0]    acc_master,
  input  logic                acc_rd,
  input  logic                acc_wr,
  input  logic                acc_ex,
  input  logic                acc_super,
  input  logic [PID_W-1:0]    acc_pid,
  output logic                res_valid,
  output logic                res_hit,
  output logic                res_allow,
  output logic [1:0]          res_class
);

  logic [ADDR_W-1:0]   t_start  [NREG];
  logic [ADDR_W-1:0]   t_end    [NREG];
  logic                t_valid  [NREG];
  logic [RIGHTS_W-1:0] t_rights [NREG];
  logic [PID_W-1:0]    t_pid    [NREG];
  logic [PID_W-1:0]    t_mask   [NREG];

  logic [NREG-1:0] hit_vec, grant_vec;
  logic            v_hit, v_allow;
  hit_class_e      v_cls;

  mpu_desc_store #(
    .NREG(NREG), .ADDR_W(ADDR_W), .PID_W(PID_W), .RIGHTS_W(RIGHTS_W)
  ) u_store (
    .clk(clk), .rst(rst), .we(cfg_we), .idx(cfg_idx),
    .start_in(cfg_start), .end_in(cfg_end), .valid_in(cfg_valid),
    .rights_in(cfg_rights), .pid_in(cfg_pid), .mask_in(cfg_pid_mask),
    .r_start(t_start), .r_end(t_end), .r_valid(t_valid),
    .r_rights(t_rights), .r_pid(t_pid), .r_mask(t_mask)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_region
    mpu_region_eval #(
      .ADDR_W(ADDR_W), .PID_W(PID_W), .GRAN_BITS(GRAN_BITS), .NRXW(NRXW), .NRW(NRW)
    ) u_eval (
      .reg_start(t_start[g]), .reg_end(t_end[g]), .reg_valid(t_valid[g]),
      .reg_rights(t_rights[g]), .reg_pid(t_pid[g]), .reg_mask(t_mask[g]),
      .addr(acc_addr), .master(acc_master),
      .want_rd(acc_rd), .want_wr(acc_wr), .want_ex(acc_ex),
      .is_super(acc_super), .pid(acc_pid),
      .hit(hit_vec[g]), .grant(grant_vec[g])
    );
  end

  mpu_verdict #(.NREG(NREG)) u_verdict (
    .hit_vec(hit_vec), .grant_vec(grant_vec), .enable(chk_enable),
    .any_hit(v_hit), .allow(v_allow), .cls(v_cls)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_allow <= 1'b0;
      res_class <= 2'd0;
    end else begin
      res_valid <= acc_valid;
      if (acc_valid) begin
        res_hit   <= v_hit;
        res_allow <= v_allow;
        res_class <= v_cls;
      end
    end
  end

endmodule

// File: rtl/mpu_region_checker_sva.sv
module mpu_region_checker_sva #(
  parameter int NRXW  = 4,
  parameter int MST_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             chk_enable,
  input logic             acc_valid,
  input logic [MST_W-1:0] acc_master,
  input logic             acc_ex,
  input logic             res_valid,
  input logic             res_hit,
  input logic             res_allow,
  input logic [1:0]       res_class
);

  p_result_follows_r11: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> res_valid);

  p_no_result_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !res_valid);

  p_hold_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> ($stable(res_allow) && $stable(res_hit) && $stable(res_class)));

  p_disabled_open_r4: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !chk_enable) |=> (res_allow && !res_hit && res_class == 2'd0));

  p_miss_denies_r9: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && chk_enable) |=> (res_class != 2'd0 || !res_allow));

  p_no_exec_rw_r7: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && chk_enable && acc_ex && acc_master >= MST_W'(NRXW)) |=> !res_allow);

  p_class_legal_r10: assert property (@(posedge clk) disable iff (rst)
    res_class != 2'd3);

endmodule

bind mpu_region_checker mpu_region_checker_sva #(.NRXW(NRXW), .MST_W(MST_W)) u_sva (
  .clk(clk), .rst(rst), .chk_enable(chk_enable), .acc_valid(acc_valid),
  .acc_master(acc_master), .acc_ex(acc_ex), .res_valid(res_valid),
  .res_hit(res_hit), .res_allow(res_allow), .res_class(res_class)
);

// File: tb/mpu_region_checker_tb.sv
module mpu_region_checker_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [31:0] cfg_start = '0, cfg_end = '0, cfg_rights = '0;
  logic        cfg_valid = 1'b0;
  logic [7:0]  cfg_pid = '0, cfg_pid_mask = '0;
  logic        chk_enable = 1'b0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [2:0]  acc_master = '0;
  logic        acc_rd = 1'b0, acc_wr = 1'b0, acc_ex = 1'b0, acc_super = 1'b0;
  logic [7:0]  acc_pid = '0;
  logic        res_valid, res_hit, res_allow;
  logic [1:0]  res_class;

  always #10 clk = ~clk;

  mpu_region_checker dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_start(cfg_start), .cfg_end(cfg_end), .cfg_valid(cfg_valid),
    .cfg_rights(cfg_rights), .cfg_pid(cfg_pid), .cfg_pid_mask(cfg_pid_mask),
    .chk_enable(chk_enable), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_master(acc_master), .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_ex(acc_ex),
    .acc_super(acc_super), .acc_pid(acc_pid), .res_valid(res_valid),
    .res_hit(res_hit), .res_allow(res_allow), .res_class(res_class)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench-side copy of the programmed descriptors
  logic [31:0] m_start [8];
  logic [31:0] m_end   [8];
  logic        m_valid [8];
  logic [31:0] m_rights[8];
  logic [7:0]  m_pid   [8];
  logic [7:0]  m_mask  [8];

  logic [3:0] exp_q[$];   // {allow, hit, class}
  string      tag_q[$];

  function automatic logic [5:0] fx(input bit pe, input logic [1:0] sup, input logic [2:0] usr);
    return {pe, sup, usr};
  endfunction

  function automatic logic [3:0] model(input logic [31:0] a, input int m, input bit rd,
      input bit wr, input bit ex, input bit sup, input logic [7:0] pid, input bit en);
    int cnt = 0;
    bit any = 0;
    logic [2:0] p;
    bit pid_ok;
    logic [5:0] f;
    logic [1:0] f2;
    logic [1:0] cls;
    if (!en) return {1'b1, 1'b0, 2'd0};
    for (int r = 0; r < 8; r++) begin
      if (m_valid[r] && a >= (m_start[r] & ~32'h1F) && a <= (m_end[r] | 32'h1F)) begin
        if (m < 4) begin
          f = 6'((m_rights[r] >> (6*m)) & 32'h3F);
          pid_ok = !f[5] || (((pid ^ m_pid[r]) & ~m_mask[r]) == 8'h00);
          if (!sup) p = f[2:0];
          else case (f[4:3])
            2'd0: p = 3'b111;
            2'd1: p = 3'b101;
            2'd2: p = 3'b110;
            default: p = f[2:0];
          endcase
        end else begin
          f2 = 2'((m_rights[r] >> (24 + 2*(m-4))) & 32'h3);
          p = {f2[0], f2[1], 1'b0};
          pid_ok = 1'b1;
        end
        if (pid_ok) begin
          cnt++;
          if ((!rd || p[2]) && (!wr || p[1]) && (!ex || p[0])) any = 1;
        end
      end
    end
    cls = (cnt == 0) ? 2'd0 : (cnt == 1) ? 2'd1 : 2'd2;
    return {any, cnt != 0, cls};
  endfunction

  task automatic write_desc(input int idx, input logic [31:0] s, input logic [31:0] e,
      input bit v, input logic [31:0] rt, input logic [7:0] pid, input logic [7:0] mk);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_start = s; cfg_end = e;
    cfg_valid = v; cfg_rights = rt; cfg_pid = pid; cfg_pid_mask = mk;
    m_start[idx] = s; m_end[idx] = e; m_valid[idx] = v;
    m_rights[idx] = rt; m_pid[idx] = pid; m_mask[idx] = mk;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(input logic [31:0] a, input int m, input bit rd, input bit wr,
      input bit ex, input bit sup, input logic [7:0] pid, input string tag);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_master = 3'(m);
    acc_rd = rd; acc_wr = wr; acc_ex = ex; acc_super = sup; acc_pid = pid;
    exp_q.push_back(model(a, m, rd, wr, ex, sup, pid, chk_enable));
    tag_q.push_back(tag);
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  // Monitor: compares each produced result with the queued expectation
  always @(negedge clk) begin
    if (!rst && res_valid && !done) begin
      logic [3:0] e;
      string t;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R11 unexpected result: got valid with empty queue, expected none");
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({res_allow, res_hit, res_class} !== e) begin
          errors++;
          $display("FAIL %s: allow/hit/class actual %b/%b/%0d expected %b/%b/%0d",
                   t, res_allow, res_hit, res_class, e[3], e[2], e[1:0]);
        end
      end
    end
  end

  task automatic direct(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout, expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rw0, rw1;
    logic        held_allow;
    for (int i = 0; i < 8; i++) begin
      m_start[i] = '0; m_end[i] = '0; m_valid[i] = 0;
      m_rights[i] = '0; m_pid[i] = '0; m_mask[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    direct(res_valid === 1'b0 && res_allow === 1'b0 && res_class === 2'd0 && res_hit === 1'b0,
           $sformatf("R11 reset state: actual v%b a%b h%b c%0d expected all zero",
                     res_valid, res_allow, res_hit, res_class));

    // R4: checking off lets everything through
    chk_enable = 1'b0;
    access(32'h2000_0000, 5, 0, 0, 1, 0, 8'h00, "R4 disabled exec by rw master");
    access(32'h0000_0040, 0, 1, 1, 0, 0, 8'h00, "R4 disabled read-write");

    // R9: enabled with no regions denies
    chk_enable = 1'b1;
    access(32'h1000_0000, 0, 1, 0, 0, 0, 8'h00, "R9 miss with empty table");

    // Region 0: rich rights word
    rw0 = {2'b00, 2'b11, 2'b10, 2'b01,
           fx(1, 2'd0, 3'd7), fx(0, 2'd2, 3'd0), fx(0, 2'd1, 3'd4), fx(0, 2'd3, 3'd7)};
    write_desc(0, 32'h1000_0013, 32'h1000_00E0, 1, rw0, 8'h5A, 8'h0F);

    access(32'h1000_0000, 0, 1, 0, 0, 0, 8'h00, "R1 first byte of start granule");
    access(32'h0FFF_FFFF, 0, 1, 0, 0, 0, 8'h00, "R1 byte below start granule");
    access(32'h1000_00FF, 0, 1, 0, 0, 0, 8'h00, "R2 last byte of end granule");
    access(32'h1000_0100, 0, 1, 0, 0, 0, 8'h00, "R2 byte after end granule");

    access(32'h1000_0040, 0, 0, 0, 1, 0, 8'h00, "R5 user code 7 execute");
    access(32'h1000_0040, 1, 1, 0, 0, 0, 8'h00, "R5 user code 4 read");
    access(32'h1000_0040, 1, 0, 1, 0, 0, 8'h00, "R5 user code 4 write denied");
    access(32'h1000_0040, 2, 1, 0, 0, 0, 8'h00, "R5 user code 0 read denied");

    access(32'h1000_0040, 1, 0, 0, 1, 1, 8'h00, "R6 super code 1 execute");
    access(32'h1000_0040, 1, 0, 1, 0, 1, 8'h00, "R6 super code 1 write denied");
    access(32'h1000_0040, 2, 1, 1, 0, 1, 8'h00, "R6 super code 2 read-write");
    access(32'h1000_0040, 2, 0, 0, 1, 1, 8'h00, "R6 super code 2 execute denied");
    access(32'h1000_0040, 0, 1, 1, 1, 1, 8'h00, "R6 super code 3 follows user 7");

    access(32'h1000_0040, 4, 1, 0, 0, 0, 8'h00, "R7 master4 read");
    access(32'h1000_0040, 4, 0, 1, 0, 1, 8'h00, "R7 master4 write denied");
    access(32'h1000_0040, 5, 0, 1, 0, 0, 8'h00, "R7 master5 write");
    access(32'h1000_0040, 5, 1, 0, 0, 0, 8'h00, "R7 master5 read denied");
    access(32'h1000_0040, 6, 0, 0, 1, 1, 8'h00, "R7 master6 execute denied");
    access(32'h1000_0040, 7, 1, 0, 0, 0, 8'h00, "R7 master7 read denied");

    access(32'h1000_0040, 3, 1, 0, 0, 0, 8'h53, "R8 pid differs only in masked bits");
    access(32'h1000_0040, 3, 1, 0, 0, 0, 8'h4A, "R8 pid differs in compared bit");
    access(32'h1000_0040, 0, 1, 0, 0, 0, 8'hC3, "R8 pid ignored when enable bit clear");

    // R3: overlapping region that is not valid
    rw1 = {8'h00, fx(0, 2'd3, 3'd0), fx(0, 2'd3, 3'd0), fx(0, 2'd3, 3'd2), fx(0, 2'd3, 3'd0)};
    write_desc(1, 32'h1000_0080, 32'h1000_0FFF, 0, rw1, 8'h00, 8'h00);
    access(32'h1000_0090, 1, 0, 1, 0, 0, 8'h00, "R3 invalid region not hit");

    // R10 / R9: make it valid, overlap gives class 2 and write via region 1
    write_desc(1, 32'h1000_0080, 32'h1000_0FFF, 1, rw1, 8'h00, 8'h00);
    access(32'h1000_0090, 1, 0, 1, 0, 0, 8'h00, "R10 two regions hit, R9 second grants");
    access(32'h1000_0090, 1, 1, 0, 0, 0, 8'h00, "R9 first grants read in overlap");
    access(32'h1000_0090, 2, 1, 0, 0, 0, 8'h00, "R9 neither region grants");
    access(32'h1000_0800, 1, 0, 1, 0, 0, 8'h00, "R10 single hit in region 1 only");

    // R11: idle cycles hold outputs and keep valid low
    held_allow = res_allow;
    repeat (3) @(negedge clk);
    direct(res_valid === 1'b0 && res_allow === held_allow,
           $sformatf("R11 idle: actual v%b a%b expected v0 a%b", res_valid, res_allow, held_allow));

    repeat (2) @(negedge clk);
    direct(exp_q.size() == 0,
           $sformatf("R11 results pending: actual %0d expected 0", exp_q.size()));
    finish_run();
  end

endmodule